// File: doc/BRIEF.md
# Control-Line Steered Integer ALU with Flags

This block is the integer datapath of a small load/store core. It takes no opcode. The decoder in front of it drives a handful of control lines instead:
- an invert line for each operand;
- a pass line for each operand;
- three bitwise selects (AND, OR, XOR);
- a carry-use line together with the carry flag the core currently holds.

All sixteen classic data-processing operations come out of one adder and one bitwise unit:
- add, add-with-carry, subtract, subtract-with-carry, reverse subtract and reverse subtract-with-carry;
- compare and compare-negative, which are the adder operations with the result discarded;
- test and test-equivalence, which are AND and XOR with the result discarded;
- AND, OR, XOR, bit clear, move and move-inverted.

Each operand first passes through an optional bitwise inversion. The adder then sums the two conditioned operands plus a carry-in. When the carry-use line is high, the carry-in is the incoming carry flag. When it is low, the carry-in is forced to 1 if either operand is inverted, which gives two's-complement subtraction, and forced to 0 otherwise.

The result and the four flags are held in registers that update on the rising clock edge. The flags are N (sign), Z (zero), C (carry) and V (signed overflow). C and V change only on adder operations. N and Z follow every result. A synchronous active-high reset clears the result and all four flags.

Top module: `flagalu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `flag_n`, `flag_z`, `flag_c` and `flag_v` become 0 after that edge.
- R2: With every control line low, the value after the next edge is `opa + opb` modulo 2^32. This covers add and compare-negative.
- R3: With only `inv_b` high, the value after the next edge is `opa - opb` modulo 2^32, and `flag_c` is 1 exactly when `opa >= opb` unsigned. This covers subtract and compare.
- R4: With only `inv_a` high, the value after the next edge is `opb - opa` modulo 2^32. This is reverse subtract.
- R5: With `carry_use` high, the adder carry-in equals `carry_flag_in`. Add-with-carry gives `opa+opb+cf`. Subtract-with-carry gives `opa-opb-1+cf`. Reverse subtract-with-carry gives `opb-opa-1+cf`.
- R6: With `carry_use` low, `carry_flag_in` has no effect on `result` or any flag.
- R7: `sel_and`, `sel_or` and `sel_xor` give AND, OR and XOR of the conditioned operands. With `inv_b` high and `sel_and` high, the result is `opa & ~opb` (bit clear).
- R8: `pass_b` gives `opb`. `pass_b` with `inv_b` gives `~opb`. `opa` has no effect in either case.
- R9: On adder operations, `flag_c` is the adder carry-out. On any operation with a pass or bitwise select high, `flag_c` and `flag_v` keep their previous values.
- R10: `flag_v` is set when the signed sum of the conditioned operands plus the carry-in falls outside the range -2^31 to 2^31-1.
- R11: After every edge outside reset, `flag_n` equals `result[31]` and `flag_z` is 1 exactly when `result` is zero.
- R12: `pass_a` gives `opa`, and gives `~opa` when `inv_a` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| inv_a | input | 1 | Invert the first operand before use |
| inv_b | input | 1 | Invert the second operand before use |
| pass_a | input | 1 | Result is the conditioned first operand |
| pass_b | input | 1 | Result is the conditioned second operand |
| sel_and | input | 1 | Result is the bitwise AND |
| sel_or | input | 1 | Result is the bitwise OR |
| sel_xor | input | 1 | Result is the bitwise XOR |
| carry_use | input | 1 | Take the adder carry-in from `carry_flag_in` |
| carry_flag_in | input | 1 | Carry flag held by the core |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Registered sign flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The result and all four flags are due exactly one rising edge after the operands and controls are applied, because only one register stage lies on the path. The bench changes inputs on the falling edge. It advances its reference model by one step for that edge and compares at the following falling edge, so every comparison falls in the cycle the output is due. The held C and V flags are predicted from the model's own record of the previous adder operation. Directed cases are ordered so that a logic or move operation follows an operation that set both C and V.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

    localparam int unsigned ALU_W = 32;

    typedef struct packed {
        logic inv_a;
        logic inv_b;
        logic pass_a;
        logic pass_b;
        logic sel_and;
        logic sel_or;
        logic sel_xor;
        logic carry_use;
        logic carry_flag;
    } alu_ctrl_t;

    typedef enum logic [2:0] {
        UNIT_SUM    = 3'd0,
        UNIT_AND    = 3'd1,
        UNIT_OR     = 3'd2,
        UNIT_XOR    = 3'd3,
        UNIT_PASS_A = 3'd4,
        UNIT_PASS_B = 3'd5
    } alu_unit_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    // Fixed precedence when more than one select is (illegally) raised.
    function automatic alu_unit_e pick_unit(alu_ctrl_t c);
        if (c.pass_b)       return UNIT_PASS_B;
        else if (c.pass_a)  return UNIT_PASS_A;
        else if (c.sel_and) return UNIT_AND;
        else if (c.sel_or)  return UNIT_OR;
        else if (c.sel_xor) return UNIT_XOR;
        else                return UNIT_SUM;
    endfunction

    // Carry into the adder: flag-driven, or forced for two's complement.
    function automatic logic carry_seed(alu_ctrl_t c);
        return c.carry_use ? c.carry_flag : (c.inv_a | c.inv_b);
    endfunction

endpackage

// File: rtl/flagalu_opcond.sv
module flagalu_opcond #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    assign dout = din ^ {W{inv}};
endmodule

// File: rtl/flagalu_adder.sv
module flagalu_adder #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input  logic [W-1:0] ea,
    input  logic [W-1:0] eb,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (ea[MSB] == eb[MSB]) && (wide[MSB] != ea[MSB]);
    end
endmodule

// File: rtl/flagalu_resmux.sv
module flagalu_resmux #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input  flagalu_pkg::alu_unit_e unit,
    input  logic [W-1:0]           ea,
    input  logic [W-1:0]           eb,
    input  logic [W-1:0]           sum,
    output logic [W-1:0]           res
);
    import flagalu_pkg::*;

    always_comb begin
        case (unit)
            UNIT_AND:    res = ea & eb;
            UNIT_OR:     res = ea | eb;
            UNIT_XOR:    res = ea ^ eb;
            UNIT_PASS_A: res = ea;
            UNIT_PASS_B: res = eb;
            default:     res = sum;
        endcase
    end
endmodule

// File: rtl/flagalu_flagcalc.sv
module flagalu_flagcalc #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input  flagalu_pkg::alu_unit_e   unit,
    input  logic [W-1:0]             res,
    input  logic                     cout,
    input  logic                     ovf,
    input  flagalu_pkg::alu_flags_t  prev,
    output flagalu_pkg::alu_flags_t  next
);
    import flagalu_pkg::*;

    logic arith;

    always_comb begin
        arith  = (unit == UNIT_SUM);
        next.n = res[W-1];
        next.z = (res == '0);
        next.c = arith ? cout : prev.c;
        next.v = arith ? ovf  : prev.v;
    end
endmodule

// File: rtl/flagalu_core.sv
module flagalu_core #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         inv_a,
    input  logic         inv_b,
    input  logic         pass_a,
    input  logic         pass_b,
    input  logic         sel_and,
    input  logic         sel_or,
    input  logic         sel_xor,
    input  logic         carry_use,
    input  logic         carry_flag_in,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    import flagalu_pkg::*;

    localparam int unsigned NUM_OPS = 2;

    alu_ctrl_t  ctrl;
    alu_unit_e  unit;
    alu_flags_t flags_q, flags_d;

    logic [NUM_OPS-1:0][W-1:0] raw_op, eff_op;
    logic [NUM_OPS-1:0]        inv_op;
    logic [W-1:0]              sum, res_d, result_q;
    logic                      cin, cout, ovf;

    always_comb begin
        ctrl.inv_a      = inv_a;
        ctrl.inv_b      = inv_b;
        ctrl.pass_a     = pass_a;
        ctrl.pass_b     = pass_b;
        ctrl.sel_and    = sel_and;
        ctrl.sel_or     = sel_or;
        ctrl.sel_xor    = sel_xor;
        ctrl.carry_use  = carry_use;
        ctrl.carry_flag = carry_flag_in;
    end

    assign unit      = pick_unit(ctrl);
    assign cin       = carry_seed(ctrl);
    assign raw_op[0] = opa;
    assign raw_op[1] = opb;
    assign inv_op    = {ctrl.inv_b, ctrl.inv_a};

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_opcond
        flagalu_opcond #(.W(W)) u_cond (
            .din  (raw_op[gi]),
            .inv  (inv_op[gi]),
            .dout (eff_op[gi])
        );
    end

    flagalu_adder #(.W(W)) u_adder (
        .ea   (eff_op[0]),
        .eb   (eff_op[1]),
        .cin  (cin),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    flagalu_resmux #(.W(W)) u_mux (
        .unit (unit),
        .ea   (eff_op[0]),
        .eb   (eff_op[1]),
        .sum  (sum),
        .res  (res_d)
    );

    flagalu_flagcalc #(.W(W)) u_flags (
        .unit (unit),
        .res  (res_d),
        .cout (cout),
        .ovf  (ovf),
        .prev (flags_q),
        .next (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            result_q <= res_d;
            flags_q  <= flags_d;
        end
    end

    assign result = result_q;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

endmodule

// File: rtl/flagalu_checker.sv
module flagalu_checker #(
    parameter int unsigned W = flagalu_pkg::ALU_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         inv_a,
    input logic         inv_b,
    input logic         pass_a,
    input logic         pass_b,
    input logic         sel_and,
    input logic         sel_or,
    input logic         sel_xor,
    input logic         carry_use,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    logic any_sel, plain_add, sub_only, move_b;

    assign any_sel   = pass_a | pass_b | sel_and | sel_or | sel_xor;
    assign plain_add = !any_sel && !inv_a && !inv_b && !carry_use;
    assign sub_only  = !any_sel && !inv_a &&  inv_b && !carry_use;
    assign move_b    = pass_b && !pass_a && !sel_and && !sel_or && !sel_xor && !inv_b;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result == '0) && !flag_n && !flag_z && !flag_c && !flag_v);

    // Also covers R6: carry_flag_in is left free here.
    assert_plain_add_R2: assert property (@(posedge clk) disable iff (rst)
        plain_add |=> result == $past(opa) + $past(opb));

    assert_subtract_R3: assert property (@(posedge clk) disable iff (rst)
        sub_only |=> result == $past(opa) - $past(opb));

    assert_move_b_R8: assert property (@(posedge clk) disable iff (rst)
        move_b |=> result == $past(opb));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        any_sel |=> $stable(flag_c) && $stable(flag_v));

    assert_nz_track_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flag_z == (result == '0)) && (flag_n == result[W-1]));

endmodule

bind flagalu_core flagalu_checker #(.W(W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .opa       (opa),
    .opb       (opb),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .pass_a    (pass_a),
    .pass_b    (pass_b),
    .sel_and   (sel_and),
    .sel_or    (sel_or),
    .sel_xor   (sel_xor),
    .carry_use (carry_use),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/flagalu_core_test.sv
module flagalu_core_test;

    // Control word bit order: [8]inv_a [7]inv_b [6]pass_a [5]pass_b
    // [4]and [3]or [2]xor [1]carry_use [0]carry_flag_in
    localparam logic [8:0] OP_ADD = 9'b000000000;
    localparam logic [8:0] OP_SUB = 9'b010000000;
    localparam logic [8:0] OP_RSB = 9'b100000000;
    localparam logic [8:0] OP_ADC = 9'b000000010;
    localparam logic [8:0] OP_SBC = 9'b010000010;
    localparam logic [8:0] OP_RSC = 9'b100000010;
    localparam logic [8:0] OP_AND = 9'b000010000;
    localparam logic [8:0] OP_OR  = 9'b000001000;
    localparam logic [8:0] OP_XOR = 9'b000000100;
    localparam logic [8:0] OP_BIC = 9'b010010000;
    localparam logic [8:0] OP_MOV = 9'b000100000;
    localparam logic [8:0] OP_MVN = 9'b010100000;
    localparam logic [8:0] OP_PA  = 9'b001000000;
    localparam logic [8:0] OP_PNA = 9'b101000000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opa, opb;
    logic        inv_a, inv_b, pass_a, pass_b, sel_and, sel_or, sel_xor;
    logic        carry_use, carry_flag_in;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_res;
    logic        m_n, m_z, m_c, m_v;

    always #2 clk = ~clk;

    flagalu_core uut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .inv_a(inv_a), .inv_b(inv_b), .pass_a(pass_a), .pass_b(pass_b),
        .sel_and(sel_and), .sel_or(sel_or), .sel_xor(sel_xor),
        .carry_use(carry_use), .carry_flag_in(carry_flag_in),
        .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic model(input logic r, input logic [31:0] a, input logic [31:0] b,
                         input logic [8:0] c);
        logic [31:0] ea, eb;
        longint      u, s;
        int          cin;
        if (r) begin
            m_res = 0; m_n = 0; m_z = 0; m_c = 0; m_v = 0;
            return;
        end
        ea = c[8] ? ~a : a;
        eb = c[7] ? ~b : b;
        if (c[5])      m_res = eb;
        else if (c[6]) m_res = ea;
        else if (c[4]) m_res = ea & eb;
        else if (c[3]) m_res = ea | eb;
        else if (c[2]) m_res = ea ^ eb;
        else begin
            cin   = c[1] ? int'(c[0]) : int'(c[8] | c[7]);
            u     = longint'(ea) + longint'(eb) + longint'(cin);
            s     = longint'($signed(ea)) + longint'($signed(eb)) + longint'(cin);
            m_res = u[31:0];
            m_c   = (u >= 64'sh1_0000_0000);
            m_v   = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        m_n = m_res[31];
        m_z = (m_res == 32'd0);
    endtask

    // Drive on a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input logic r, input logic [31:0] a, input logic [31:0] b,
                        input logic [8:0] c, input string tag);
        rst = r; opa = a; opb = b;
        {inv_a, inv_b, pass_a, pass_b, sel_and, sel_or, sel_xor, carry_use, carry_flag_in} = c;
        model(r, a, b, c);
        @(posedge clk);
        @(negedge clk);
        tests++;
        if ({result, flag_n, flag_z, flag_c, flag_v} !== {m_res, m_n, m_z, m_c, m_v}) begin
            fails++;
            $display("FAIL %s: got %h nzcv=%b%b%b%b expected %h nzcv=%b%b%b%b", tag,
                     result, flag_n, flag_z, flag_c, flag_v, m_res, m_n, m_z, m_c, m_v);
        end
    endtask

    task automatic expect_const(input logic [31:0] res, input logic [3:0] nzcv, input string tag);
        tests++;
        if ({result, flag_n, flag_z, flag_c, flag_v} !== {res, nzcv}) begin
            fails++;
            $display("FAIL %s: got %h nzcv=%b%b%b%b expected %h nzcv=%b", tag,
                     result, flag_n, flag_z, flag_c, flag_v, res, nzcv);
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog R1: got hung run expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        // R1: reset with nonzero stimulus on every input
        step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'b111111111, "R1 reset");
        step(1'b1, 32'h1234_5678, 32'h8765_4321, OP_ADD, "R1 reset");
        expect_const(32'h0, 4'b0000, "R1 reset state");

        // R2, R9, R11: wrap to zero with carry out
        step(1'b0, 32'hFFFF_FFFF, 32'h1, OP_ADD, "R2 add wrap");
        expect_const(32'h0, 4'b0110, "R2 R11 add wrap");
        // R10: signed overflow on add
        step(1'b0, 32'h7FFF_FFFF, 32'h1, OP_ADD, "R10 add ovf");
        expect_const(32'h8000_0000, 4'b1001, "R10 add ovf");
        // R3: subtract with and without borrow
        step(1'b0, 32'h3, 32'h1, OP_SUB, "R3 sub");
        expect_const(32'h2, 4'b0010, "R3 sub no borrow");
        step(1'b0, 32'h1, 32'h3, OP_SUB, "R3 sub");
        expect_const(32'hFFFF_FFFE, 4'b1000, "R3 sub borrow");
        // R4: reverse subtract
        step(1'b0, 32'h1, 32'h3, OP_RSB, "R4 rsb");
        expect_const(32'h2, 4'b0010, "R4 rsb");
        // R5: carry-driven family
        step(1'b0, 32'd5, 32'd7, OP_ADC | 9'b1, "R5 adc");
        expect_const(32'd13, 4'b0000, "R5 adc cf=1");
        step(1'b0, 32'd5, 32'd3, OP_SBC, "R5 sbc");
        expect_const(32'd1, 4'b0010, "R5 sbc cf=0");
        step(1'b0, 32'd3, 32'd5, OP_RSC, "R5 rsc");
        expect_const(32'd1, 4'b0010, "R5 rsc cf=0");
        // R6: incoming flag ignored without carry_use
        step(1'b0, 32'd5, 32'd7, OP_ADD | 9'b1, "R6 flag ignored");
        expect_const(32'd12, 4'b0000, "R6 flag ignored");
        // R10: overflow on subtract, sets C and V for the hold checks
        step(1'b0, 32'h8000_0000, 32'h1, OP_SUB, "R10 sub ovf");
        expect_const(32'h7FFF_FFFF, 4'b0011, "R10 sub ovf");
        // R7, R9: logic ops keep C and V
        step(1'b0, 32'hF0F0_F0F0, 32'h0FF0_0FF0, OP_AND, "R7 and");
        expect_const(32'h00F0_00F0, 4'b0011, "R7 R9 and hold");
        step(1'b0, 32'hFFFF_0000, 32'h0F0F_0F0F, OP_BIC, "R7 bic");
        expect_const(32'hF0F0_0000, 4'b1011, "R7 bic");
        step(1'b0, 32'h5A5A_5A5A, 32'h5A5A_5A5A, OP_XOR, "R7 xor");
        expect_const(32'h0, 4'b0111, "R7 R11 xor equal");
        step(1'b0, 32'h1200_0034, 32'h0000_5600, OP_OR, "R7 or");
        expect_const(32'h1200_5634, 4'b0011, "R7 or");
        // R8: moves ignore opa
        step(1'b0, 32'hDEAD_BEEF, 32'h0, OP_MOV, "R8 mov");
        expect_const(32'h0, 4'b0111, "R8 mov");
        step(1'b0, 32'hDEAD_BEEF, 32'h0, OP_MVN, "R8 mvn");
        expect_const(32'hFFFF_FFFF, 4'b1011, "R8 mvn");
        // R12: pass first operand
        step(1'b0, 32'h1234_5678, 32'hFFFF_FFFF, OP_PA, "R12 pass a");
        expect_const(32'h1234_5678, 4'b0011, "R12 pass a");
        step(1'b0, 32'h0, 32'h5, OP_PNA, "R12 pass not a");
        expect_const(32'hFFFF_FFFF, 4'b1011, "R12 pass not a");
        // R1: reset in mid-run
        step(1'b1, 32'h1, 32'h1, OP_ADD, "R1 mid reset");
        expect_const(32'h0, 4'b0000, "R1 mid reset");

        // Random legal operations against the model
        for (int i = 0; i < 600; i++) begin
            logic [8:0]  c;
            logic [31:0] a, b;
            string       t;
            a = $urandom();
            b = (i % 7 == 0) ? a : $urandom();
            case ($urandom_range(0, 13))
                0:  begin c = OP_ADD | 9'($urandom_range(0, 1)); t = "R2 R6 add"; end
                1:  begin c = OP_SUB; t = "R3 sub"; end
                2:  begin c = OP_RSB; t = "R4 rsb"; end
                3:  begin c = OP_ADC | 9'($urandom_range(0, 1)); t = "R5 adc"; end
                4:  begin c = OP_SBC | 9'($urandom_range(0, 1)); t = "R5 sbc"; end
                5:  begin c = OP_RSC | 9'($urandom_range(0, 1)); t = "R5 rsc"; end
                6:  begin c = OP_AND; t = "R7 and"; end
                7:  begin c = OP_OR;  t = "R7 or"; end
                8:  begin c = OP_XOR; t = "R7 xor"; end
                9:  begin c = OP_BIC; t = "R7 bic"; end
                10: begin c = OP_MOV; t = "R8 mov"; end
                11: begin c = OP_MVN; t = "R8 mvn"; end
                12: begin c = OP_PA;  t = "R12 pass"; end
                default: begin c = OP_SUB | 9'($urandom_range(0, 1)); t = "R9 R10 R11 sub"; end
            endcase
            step(1'b0, a, b, c, t);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule